// File: doc/BRIEF.md
# Flash Query-Mode Probe Sequencer

This block drives a simple synchronous flash bus to bring a flash bank into query mode. A bank can be built from several identical devices placed side by side. The block tries a fixed, ordered set of unlock sequences. After each one it reads back three signature locations and checks for the characters 'Q', 'R' and 'Y'. The first sequence that produces the signature wins.

Once the bank is in query mode, the block can read a run of table bytes from a requested table offset and stream them out. It then returns the bank to normal read mode with an exit sequence. Software or a boot controller starts it with one pulse. It reads back whether the signature was found, which sequence worked, and the streamed table bytes.

Command values and offsets are in device units. Every offset is multiplied by the bank scale, `DEV_BYTES × INTERLEAVE`, and added to the base address. Every command byte is copied into the low byte of each device lane of the bus word.

Top module: `qry_probe_seq`

## Requirements
- R1: After reset, `done`, `found`, `busWr`, `busRd` and `tblValid` are 0, and `attemptIdx` is 0.
- R2: Every probe attempt begins with a write of command 0xF0 at offset 0.
- R3: After the 0xF0 write, the attempts issue these writes, tried in order 0 to 4:
  - attempt 0: 0x98@0x55
  - attempt 1: 0xFF@0x0, then 0x98@0x55
  - attempt 2: 0x98@0x555
  - attempt 3: 0xAA@0x5555, then 0x55@0x2AAA, then 0x98@0x5555
  - attempt 4: 0xAA@0x555, then 0x55@0x2AA, then 0x98@0x555
- R4: Each attempt ends with reads at offsets 0x10, 0x11 and 0x12. The attempt succeeds only if the three read words equal the encoded commands 0x51, 0x52 and 0x59. A mismatch in any one of the three, including only the last, counts as a failure.
- R5: On success, `found` is 1 and `attemptIdx` holds the winning attempt number. No later attempt is issued.
- R6: If all five attempts fail, the block still runs the exit sequence. It then reports `done` = 1, `found` = 0 and `attemptIdx` = 0.
- R7: After a success with a nonzero table offset and length, the block reads `tblLen` words. Word i is read at offset `tblOfs + i`. Bits [7:0] of each word appear on `tblByte`, with a one-cycle `tblValid` pulse, in increasing order.
- R8: A table offset of 0, or a length of 0, skips the table reads entirely.
- R9: The exit sequence writes 0xF0 at offset 0 and then 0xFF at offset 0. It adds a third write of 0xF0 at offset 0 when `exitQuirk` is 1.
- R10: Every bus access holds its strobe and address for exactly `WAIT_CYC` cycles. Read data is sampled in the last of those cycles. `busWr` and `busRd` are never high together.
- R11: Every address equals `baseAddr + offset × DEV_BYTES × INTERLEAVE`. Every written word carries the command byte in bits [7:0] of each `DEV_BYTES`-wide lane, with the other bits 0.
- R12: `done` rises after the last exit write and stays high until the next `start`, which clears it. A `start` pulse while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe run (accepted only when idle) |
| baseAddr | input | ADDR_W | Bank base byte address |
| tblOfs | input | 16 | Table offset in device units; 0 means no table read |
| tblLen | input | 8 | Number of table bytes to fetch |
| exitQuirk | input | 1 | Adds the extra reset write to the exit sequence |
| busRdata | input | DEV_BYTES*INTERLEAVE*8 | Flash read data |
| busAddr | output | ADDR_W | Flash byte address |
| busWdata | output | DEV_BYTES*INTERLEAVE*8 | Flash write data |
| busWr | output | 1 | Write strobe |
| busRd | output | 1 | Read strobe |
| done | output | 1 | Run finished |
| found | output | 1 | Signature confirmed |
| attemptIdx | output | 3 | Number of the winning attempt |
| tblByte | output | 8 | Streamed table byte |
| tblValid | output | 1 | Table byte strobe |

## Verification
Two events can land in the same cycle:
- the capture of the final 'Y' comparison and the decision between the table read, the next attempt and the exit;
- the last `tblValid` pulse and the first exit write.

A flash model that answers 'Q' and 'R' correctly on every attempt but gets 'Y' right only on the chosen attempt provokes the first case. The bench judges it by the exact sequence of accesses that follows and by the reported attempt number. The second case is checked by requiring that every table byte arrives and that the exit writes follow with no gap or repeated access.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int CMD_W     = 8;
  localparam int TBL_OFS_W = 16;
  localparam int LEN_W     = 8;
  localparam int OFS_W     = TBL_OFS_W + 1;
  localparam int NUM_ATT   = 5;

  typedef enum logic [2:0] {ST_IDLE, ST_PWR, ST_PRD, ST_TRD, ST_XWR} qpsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             wr;
    logic             rd;
    logic             accEnd;
    logic             takeSig;
    logic             firstSig;
    logic             takeTbl;
    logic [CMD_W-1:0] cmd;
    logic [OFS_W-1:0] ofs;
  } qpsCtl_t;

  typedef struct packed {
    logic                 last;
    logic [CMD_W-1:0]     cmd;
    logic [TBL_OFS_W-1:0] ofs;
  } qpsOp_t;

  // write step of an unlock attempt; step 0 is always the reset command
  function automatic qpsOp_t probeOp(input logic [2:0] att, input logic [2:0] step);
    qpsOp_t op;
    op = '{1'b0, 8'hF0, 16'h0000};
    if (step != 3'd0) begin
      case (att)
        3'd0: op = '{1'b1, 8'h98, 16'h0055};
        3'd1: op = (step == 3'd1) ? '{1'b0, 8'hFF, 16'h0000} : '{1'b1, 8'h98, 16'h0055};
        3'd2: op = '{1'b1, 8'h98, 16'h0555};
        3'd3: begin
          case (step)
            3'd1:    op = '{1'b0, 8'hAA, 16'h5555};
            3'd2:    op = '{1'b0, 8'h55, 16'h2AAA};
            default: op = '{1'b1, 8'h98, 16'h5555};
          endcase
        end
        default: begin
          case (step)
            3'd1:    op = '{1'b0, 8'hAA, 16'h0555};
            3'd2:    op = '{1'b0, 8'h55, 16'h02AA};
            default: op = '{1'b1, 8'h98, 16'h0555};
          endcase
        end
      endcase
    end
    return op;
  endfunction

  function automatic logic [CMD_W-1:0] sigChar(input logic [2:0] step);
    case (step)
      3'd0:    return 8'h51;
      3'd1:    return 8'h52;
      default: return 8'h59;
    endcase
  endfunction
endpackage

// File: rtl/qps_ctrl.sv
module qps_ctrl
  import qps_pkg::*;
#(
  parameter int WAIT_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [TBL_OFS_W-1:0] tblOfs,
  input  logic [LEN_W-1:0]     tblLen,
  input  logic                 exitQuirk,
  input  logic                 sigOk,
  output qpsCtl_t              ctl,
  output logic                 done,
  output logic                 found,
  output logic [2:0]           attemptIdx
);
  localparam int WC_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  qpsState_e        state;
  logic [2:0]       attempt;
  logic [2:0]       step;
  logic [LEN_W-1:0] byteCnt;
  logic [WC_W-1:0]  waitCnt;
  logic             active;
  logic             accEnd;
  logic             exitLast;
  qpsOp_t           pOp;

  assign active   = (state != ST_IDLE);
  assign accEnd   = active && (waitCnt == WC_W'(WAIT_CYC - 1));
  assign pOp      = probeOp(attempt, step);
  assign exitLast = (step == 3'd2) || ((step == 3'd1) && !exitQuirk);

  always_comb begin
    ctl        = '0;
    ctl.accEnd = accEnd;
    case (state)
      ST_PWR: begin
        ctl.wr  = 1'b1;
        ctl.cmd = pOp.cmd;
        ctl.ofs = OFS_W'(pOp.ofs);
      end
      ST_PRD: begin
        ctl.rd       = 1'b1;
        ctl.takeSig  = 1'b1;
        ctl.firstSig = (step == 3'd0);
        ctl.cmd      = sigChar(step);
        ctl.ofs      = OFS_W'(16'h0010) + OFS_W'(step);
      end
      ST_TRD: begin
        ctl.rd      = 1'b1;
        ctl.takeTbl = 1'b1;
        ctl.ofs     = OFS_W'(tblOfs) + OFS_W'(byteCnt);
      end
      ST_XWR: begin
        ctl.wr  = 1'b1;
        ctl.cmd = (step == 3'd1) ? 8'hFF : 8'hF0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      attempt    <= '0;
      step       <= '0;
      byteCnt    <= '0;
      waitCnt    <= '0;
      done       <= 1'b0;
      found      <= 1'b0;
      attemptIdx <= '0;
    end else begin
      if (active) waitCnt <= accEnd ? '0 : waitCnt + WC_W'(1);
      case (state)
        ST_IDLE: if (start) begin
          state      <= ST_PWR;
          attempt    <= '0;
          step       <= '0;
          waitCnt    <= '0;
          done       <= 1'b0;
          found      <= 1'b0;
          attemptIdx <= '0;
        end
        ST_PWR: if (accEnd) begin
          if (pOp.last) begin
            step  <= '0;
            state <= ST_PRD;
          end else begin
            step <= step + 3'd1;
          end
        end
        ST_PRD: if (accEnd) begin
          if (step == 3'd2) begin
            step <= '0;
            if (sigOk) begin
              found      <= 1'b1;
              attemptIdx <= attempt;
              byteCnt    <= '0;
              state      <= (tblOfs != '0 && tblLen != '0) ? ST_TRD : ST_XWR;
            end else if (attempt == 3'(NUM_ATT - 1)) begin
              state <= ST_XWR;
            end else begin
              attempt <= attempt + 3'd1;
              state   <= ST_PWR;
            end
          end else begin
            step <= step + 3'd1;
          end
        end
        ST_TRD: if (accEnd) begin
          if (byteCnt == tblLen - LEN_W'(1)) begin
            step  <= '0;
            state <= ST_XWR;
          end else begin
            byteCnt <= byteCnt + LEN_W'(1);
          end
        end
        ST_XWR: if (accEnd) begin
          if (exitLast) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            step <= step + 3'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qps_dpath.sv
module qps_dpath
  import qps_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DEV_BYTES  = 2,
  parameter int INTERLEAVE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  qpsCtl_t           ctl,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DEV_BYTES*INTERLEAVE*8-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DEV_BYTES*INTERLEAVE*8-1:0] busWdata,
  output logic              busWr,
  output logic              busRd,
  output logic              sigOk,
  output logic [7:0]        tblByte,
  output logic              tblValid
);
  localparam int LANE_W = DEV_BYTES * 8;
  localparam int BUS_W  = LANE_W * INTERLEAVE;
  localparam int SCALE  = DEV_BYTES * INTERLEAVE;

  logic [BUS_W-1:0] cmdWord;
  logic             matchAcc;
  logic             wordEq;

  // command byte copied into the low byte of every device lane
  for (genvar g = 0; g < INTERLEAVE; g++) begin : gLane
    assign cmdWord[g*LANE_W +: LANE_W] = LANE_W'(ctl.cmd);
  end

  assign busAddr  = baseAddr + ADDR_W'(ctl.ofs) * ADDR_W'(SCALE);
  assign busWdata = ctl.wr ? cmdWord : '0;
  assign busWr    = ctl.wr;
  assign busRd    = ctl.rd;
  assign wordEq   = (busRdata == cmdWord);
  assign sigOk    = wordEq && (ctl.firstSig || matchAcc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchAcc <= 1'b0;
      tblValid <= 1'b0;
      tblByte  <= '0;
    end else begin
      if (ctl.takeSig && ctl.accEnd) matchAcc <= sigOk;
      tblValid <= ctl.takeTbl && ctl.accEnd;
      if (ctl.takeTbl && ctl.accEnd) tblByte <= busRdata[7:0];
    end
  end
endmodule

// File: rtl/qry_probe_seq.sv
module qry_probe_seq
  import qps_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DEV_BYTES  = 2,
  parameter int INTERLEAVE = 1,
  parameter int WAIT_CYC   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    baseAddr,
  input  logic [TBL_OFS_W-1:0] tblOfs,
  input  logic [LEN_W-1:0]     tblLen,
  input  logic                 exitQuirk,
  input  logic [DEV_BYTES*INTERLEAVE*8-1:0] busRdata,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [DEV_BYTES*INTERLEAVE*8-1:0] busWdata,
  output logic                 busWr,
  output logic                 busRd,
  output logic                 done,
  output logic                 found,
  output logic [2:0]           attemptIdx,
  output logic [7:0]           tblByte,
  output logic                 tblValid
);
  qpsCtl_t ctl;
  logic    sigOk;

  qps_ctrl #(.WAIT_CYC(WAIT_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .tblOfs(tblOfs), .tblLen(tblLen),
    .exitQuirk(exitQuirk), .sigOk(sigOk), .ctl(ctl), .done(done),
    .found(found), .attemptIdx(attemptIdx)
  );

  qps_dpath #(.ADDR_W(ADDR_W), .DEV_BYTES(DEV_BYTES), .INTERLEAVE(INTERLEAVE)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .baseAddr(baseAddr), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr), .busRd(busRd),
    .sigOk(sigOk), .tblByte(tblByte), .tblValid(tblValid)
  );
endmodule

// File: rtl/qps_checker.sv
module qps_checker (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busWr,
  input logic       busRd,
  input logic       done,
  input logic       found,
  input logic [2:0] attemptIdx,
  input logic       tblValid
);
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd));
  a_r12_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busWr && !busRd));
  a_r12_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);
  a_r12_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !done);
  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    attemptIdx <= 3'd4);
  a_r6_miss_idx_zero: assert property (@(posedge clk) disable iff (!rstN)
    (done && !found) |-> (attemptIdx == 3'd0));
  a_r7_valid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    tblValid |-> $past(busRd));
endmodule

bind qry_probe_seq qps_checker uChk (
  .clk(clk), .rstN(rstN), .start(start), .busWr(busWr), .busRd(busRd),
  .done(done), .found(found), .attemptIdx(attemptIdx), .tblValid(tblValid)
);

// File: tb/qry_probe_seq_test.sv
module qry_probe_seq_test;
  localparam int AW = 20;
  localparam int DB = 2;
  localparam int IL = 2;
  localparam int WC = 3;
  localparam int BW = DB * IL * 8;
  localparam int SC = DB * IL;
  localparam logic [AW-1:0] BASE = 20'h40000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, start, exitQuirk;
  logic [AW-1:0] baseAddr, busAddr;
  logic [15:0] tblOfs;
  logic [7:0]  tblLen, tblByte;
  logic [BW-1:0] busRdata, busWdata;
  logic busWr, busRd, done, found, tblValid;
  logic [2:0] attemptIdx;

  qry_probe_seq #(.ADDR_W(AW), .DEV_BYTES(DB), .INTERLEAVE(IL), .WAIT_CYC(WC)) uut (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .tblOfs(tblOfs),
    .tblLen(tblLen), .exitQuirk(exitQuirk), .busRdata(busRdata), .busAddr(busAddr),
    .busWdata(busWdata), .busWr(busWr), .busRd(busRd), .done(done), .found(found),
    .attemptIdx(attemptIdx), .tblByte(tblByte), .tblValid(tblValid)
  );

  int total = 0;
  int fails = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] rep(input logic [7:0] c);
    logic [BW-1:0] w;
    w = '0;
    for (int l = 0; l < IL; l++) w[l*DB*8 +: DB*8] = {{(DB*8-8){1'b0}}, c};
    return w;
  endfunction

  // flash model
  int f0Count;
  int goodAtt;
  bit failY;
  always_comb begin : model
    int rel;
    int att;
    rel = int'(busAddr) - int'(BASE);
    att = f0Count - 1;
    busRdata = '1;
    if (rel == 'h10 * SC)
      busRdata = (att == goodAtt || failY) ? rep(8'h51) : '0;
    else if (rel == 'h11 * SC)
      busRdata = (att == goodAtt || failY) ? rep(8'h52) : '0;
    else if (rel == 'h12 * SC)
      busRdata = (att == goodAtt) ? rep(8'h59) : (failY ? rep(8'h58) : '0);
    else if (rel >= 'h20 * SC && rel % SC == 0)
      busRdata = {8'hA5, 8'h5A, 8'hC3, 8'((rel / SC) * 7 + 3)};
  end

  // access log
  bit          obsWr[256];
  logic [AW-1:0] obsAddr[256];
  logic [BW-1:0] obsData[256];
  int          obsLen[256];
  int          obsN;
  logic [7:0]  tbBytes[256];
  int          tbN;
  bit          pAct, pWr;
  logic [AW-1:0] pAddr;
  logic [BW-1:0] pData;
  int          runLen;

  always @(negedge clk) begin
    bit act, same;
    act  = busWr | busRd;
    same = act && pAct && (busWr == pWr) && (busAddr == pAddr) && (busWdata == pData);
    if (same) runLen++;
    else begin
      if (pAct && obsN > 0) obsLen[obsN-1] = runLen;
      if (act && obsN < 256) begin
        obsWr[obsN] = busWr; obsAddr[obsN] = busAddr; obsData[obsN] = busWdata;
        obsN++;
        runLen = 1;
        if (busWr && busAddr == BASE && busWdata == rep(8'hF0)) f0Count++;
      end
    end
    pAct = act; pWr = busWr; pAddr = busAddr; pData = busWdata;
    if (tblValid && tbN < 256) begin tbBytes[tbN] = tblByte; tbN++; end
  end

  // expected access list
  bit          expWr[256];
  logic [AW-1:0] expAddr[256];
  logic [BW-1:0] expData[256];
  int          expN;

  task automatic pushW(input logic [7:0] c, input int ofs);
    expWr[expN] = 1'b1; expAddr[expN] = BASE + AW'(ofs * SC); expData[expN] = rep(c); expN++;
  endtask
  task automatic pushR(input int ofs);
    expWr[expN] = 1'b0; expAddr[expN] = BASE + AW'(ofs * SC); expData[expN] = '0; expN++;
  endtask

  task automatic buildExp(input int g, input bit q, input int tofs, input int tlen);
    int last;
    expN = 0;
    last = (g > 4) ? 4 : g;
    for (int a = 0; a <= last; a++) begin
      pushW(8'hF0, 0);                                   // R2
      case (a)                                           // R3
        0: pushW(8'h98, 'h55);
        1: begin pushW(8'hFF, 0); pushW(8'h98, 'h55); end
        2: pushW(8'h98, 'h555);
        3: begin pushW(8'hAA, 'h5555); pushW(8'h55, 'h2AAA); pushW(8'h98, 'h5555); end
        default: begin pushW(8'hAA, 'h555); pushW(8'h55, 'h2AA); pushW(8'h98, 'h555); end
      endcase
      pushR('h10); pushR('h11); pushR('h12);             // R4
    end
    if (g <= 4 && tofs != 0 && tlen != 0)
      for (int i = 0; i < tlen; i++) pushR(tofs + i);    // R7
    pushW(8'hF0, 0); pushW(8'hFF, 0);                    // R9
    if (q) pushW(8'hF0, 0);
  endtask

  task automatic runCase(input int g, input bit fy, input bit q, input int tofs, input int tlen, input bit poke);
    int wait_n, seqBad, dataBad, lenBad, sigReads, expSig, tblBad, expTbl, firstBad;
    bit exitOk;
    @(negedge clk);
    goodAtt = g; failY = fy; f0Count = 0; obsN = 0; tbN = 0;
    exitQuirk = q; tblOfs = 16'(tofs); tblLen = 8'(tlen); baseAddr = BASE;
    buildExp(g, q, tofs, tlen);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R12 done cleared by start", 32'(done), 0);
    if (poke) begin
      repeat (7) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 3000) begin @(negedge clk); wait_n++; end
    check(done == 1'b1, "R12 run completes", 32'(done), 1);
    repeat (4) @(negedge clk);
    check(done == 1'b1, "R12 done stays high", 32'(done), 1);

    check(obsN == expN, "R3 access count", 32'(obsN), 32'(expN));
    seqBad = 0; dataBad = 0; lenBad = 0; sigReads = 0; firstBad = -1;
    for (int i = 0; i < obsN && i < expN; i++) begin
      if (obsWr[i] != expWr[i] || obsAddr[i] != expAddr[i]) begin
        seqBad++;
        if (firstBad < 0) firstBad = i;
      end
      if (obsWr[i] && obsData[i] != expData[i]) dataBad++;
      if (obsLen[i] != WC) lenBad++;
      if (!obsWr[i] && obsAddr[i] == BASE + AW'('h12 * SC)) sigReads++;
    end
    check(seqBad == 0, "R2 R3 access order and addresses",
          (firstBad >= 0) ? 32'(obsAddr[firstBad]) : 0,
          (firstBad >= 0) ? 32'(expAddr[firstBad]) : 0);
    check(dataBad == 0, "R11 command word encoding", 32'(dataBad), 0);
    check(lenBad == 0, "R10 access length", 32'(lenBad), 0);
    expSig = (g > 4) ? 5 : g + 1;
    check(sigReads == expSig, "R4 signature attempts", 32'(sigReads), 32'(expSig));

    exitOk = (obsN >= 3);
    if (exitOk) begin
      int b;
      b = q ? obsN - 3 : obsN - 2;
      exitOk = obsWr[b] && obsData[b] == rep(8'hF0) && obsAddr[b] == BASE &&
               obsWr[b+1] && obsData[b+1] == rep(8'hFF) && obsAddr[b+1] == BASE;
      if (q) exitOk = exitOk && obsWr[b+2] && obsData[b+2] == rep(8'hF0);
      else   exitOk = exitOk && !(obsWr[obsN-3] && obsData[obsN-3] == rep(8'hFF) && obsAddr[obsN-3] == BASE);
    end
    check(exitOk, "R9 exit sequence", 32'(obsN), 32'(expN));

    if (g <= 4) begin
      check(found == 1'b1, "R5 found", 32'(found), 1);
      check(attemptIdx == 3'(g), "R5 attempt index", 32'(attemptIdx), 32'(g));
    end else begin
      check(found == 1'b0, "R6 not found", 32'(found), 0);
      check(attemptIdx == 3'd0, "R6 index zero", 32'(attemptIdx), 0);
    end

    expTbl = (g <= 4 && tofs != 0 && tlen != 0) ? tlen : 0;
    check(tbN == expTbl, (expTbl == 0) ? "R8 no table bytes" : "R7 table byte count",
          32'(tbN), 32'(expTbl));
    tblBad = 0;
    for (int i = 0; i < tbN && i < expTbl; i++)
      if (tbBytes[i] != 8'((tofs + i) * 7 + 3)) tblBad++;
    check(tblBad == 0, "R7 table byte values", 32'(tblBad), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; exitQuirk = 1'b0; tblOfs = '0; tblLen = '0;
    baseAddr = BASE; goodAtt = 0; failY = 0; f0Count = 0; obsN = 0; tbN = 0;
    pAct = 0; pWr = 0; pAddr = '0; pData = '0; runLen = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !found && !busWr && !busRd && !tblValid && attemptIdx == 0,
          "R1 reset state", {26'd0, done, found, busWr, busRd, tblValid, 1'b0}, 0);
    for (int g = 0; g <= 5; g++)
      for (int q = 0; q <= 1; q++) begin
        case ((g + q) % 4)
          0: runCase(g, 1'b0, q[0], 'h40, 3, 1'b0);
          1: runCase(g, 1'b0, q[0], 0, 4, 1'b0);      // R8 zero offset
          2: runCase(g, 1'b0, q[0], 'h31, 1, 1'b0);
          default: runCase(g, 1'b0, q[0], 'h40, 0, 1'b0); // R8 zero length
        endcase
      end
    runCase(3, 1'b1, 1'b0, 'h22, 2, 1'b1);   // R4 only Y wrong earlier, R12 busy start
    runCase(5, 1'b1, 1'b1, 'h22, 2, 1'b0);   // R6 Y never right
    runCase(4, 1'b0, 1'b1, 'h100, 5, 1'b1);  // R7 longer table, R9 quirk
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule